// File: doc/BRIEF.md
# Decode-Stage Conditional Branch Resolver

This block settles equal and not-equal conditional branches while the branch instruction sits in the decode stage of a five-stage in-order pipeline. Fetch always runs down the sequential path. The resolver compares the two register operands and builds the branch destination from the sequential address and the sign-extended word offset, all within the decode cycle. A taken branch costs only the one wrong-path instruction that has already been fetched. A taken branch turns that instruction into a bubble through a flush request to the fetch/decode pipeline register, and the same cycle steers the next-PC mux to the destination.

The register file, the operand forwarding paths and the stall generator are outside this block. The only sign of operand hazards the resolver receives is an operand-ready input. While that input is low, the resolver takes no action, and it resolves the same branch in the first cycle that the input is high. The redirect, destination and flush outputs are combinational, because fetch has to use them in the same cycle. Two registered event counters, one for taken branches and one for flush cycles, make the one-slot penalty visible at the ports.

Top module: `dec_branch_unit`

## Requirements
- R1: While `rst` is high, `redirect` and `if_flush` are 0 and `next_pc` equals `seq_pc`. On the first clock edge after reset both counters read 0.
- R2: `target_pc` always equals `seq_pc` plus `offset_ext` shifted left by two bits, taken modulo 2^XLEN. Negative offsets therefore point backwards.
- R3: With `sel_eq`=1 and `sel_ne`=0, the branch is taken exactly when `reg_a` equals `reg_b`.
- R4: With `sel_ne`=1 and `sel_eq`=0, the branch is taken exactly when `reg_a` differs from `reg_b`.
- R5: In a cycle in which a branch is taken, `redirect`=1 and `next_pc` equals `target_pc`. In every other cycle, `redirect`=0 and `next_pc` equals `seq_pc`, so a branch that is not taken costs no slot.
- R6: `if_flush` is high in exactly the cycles in which `redirect` is high, which gives one bubble per taken branch.
- R7: While `opnd_ready` is 0, `redirect` and `if_flush` stay 0 whatever the operands are. The branch is resolved in the first cycle in which `opnd_ready` is 1 again.
- R8: When both `sel_eq` and `sel_ne` are 1, or when both are 0, no redirect and no flush occur.
- R9: Each clock edge adds 1 to `taken_count` after a cycle with a taken branch, and adds 1 to `flush_count` after a cycle with `if_flush` high. Both counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_pc | input | XLEN | Sequential address (PC+4) of the instruction in decode |
| offset_ext | input | XLEN | Sign-extended 16-bit branch offset, in words |
| reg_a | input | XLEN | First register operand |
| reg_b | input | XLEN | Second register operand |
| sel_eq | input | 1 | Decoded branch-if-equal |
| sel_ne | input | 1 | Decoded branch-if-not-equal |
| opnd_ready | input | 1 | Operands valid; low means the decode stage is stalled |
| redirect | output | 1 | Next-PC mux select: 1 picks the branch destination |
| next_pc | output | XLEN | Selected next fetch address |
| target_pc | output | XLEN | Computed branch destination |
| if_flush | output | 1 | Squash the fetch/decode register into a bubble |
| taken_count | output | CNT_W | Number of taken branches since reset |
| flush_count | output | CNT_W | Number of flush cycles since reset |

## Verification
The bound assertions check the following on every cycle: the flush and the redirect agree, nothing is redirected while the operands are not ready, a pair of conflicting selects or no select never redirects, reset stays quiet, and each counter advances by exactly the previous cycle's event. Only the bench scenarios can show the data-dependent side. That covers equal versus unequal operands for each branch kind, backward and forward destinations with address wraparound, a branch held across a stall that resolves once, and the counters staying equal over a long mixed run.

// File: rtl/dec_branch_pkg.sv
package dec_branch_pkg;
  typedef enum logic [1:0] {
    BK_NONE = 2'd0,
    BK_EQ   = 2'd1,
    BK_NE   = 2'd2
  } br_kind_e;

  localparam int OFFSET_SHIFT = 2;
endpackage

// File: rtl/dec_branch_kind.sv
module dec_branch_kind
  import dec_branch_pkg::*;
(
  input  logic     sel_eq,
  input  logic     sel_ne,
  output br_kind_e kind
);
  always_comb begin
    unique case ({sel_ne, sel_eq})
      2'b01:   kind = BK_EQ;
      2'b10:   kind = BK_NE;
      default: kind = BK_NONE;
    endcase
  end
endmodule

// File: rtl/dec_branch_target.sv
module dec_branch_target
  import dec_branch_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] offset_ext,
  output logic [XLEN-1:0] target_pc
);
  logic [XLEN-1:0] byte_off;

  assign byte_off  = {offset_ext[XLEN-1-OFFSET_SHIFT:0], {OFFSET_SHIFT{1'b0}}};
  assign target_pc = seq_pc + byte_off;
endmodule

// File: rtl/dec_branch_cmp.sv
module dec_branch_cmp
  import dec_branch_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] reg_a,
  input  logic [XLEN-1:0] reg_b,
  input  br_kind_e        kind,
  output logic            take
);
  logic same;

  assign same = (reg_a == reg_b);

  always_comb begin
    unique case (kind)
      BK_EQ:   take = same;
      BK_NE:   take = ~same;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/dec_branch_evcnt.sv
module dec_branch_evcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (bump) count <= count + ONE;
  end
endmodule

// File: rtl/dec_branch_unit.sv
module dec_branch_unit
  import dec_branch_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  seq_pc,
  input  logic [XLEN-1:0]  offset_ext,
  input  logic [XLEN-1:0]  reg_a,
  input  logic [XLEN-1:0]  reg_b,
  input  logic             sel_eq,
  input  logic             sel_ne,
  input  logic             opnd_ready,
  output logic             redirect,
  output logic [XLEN-1:0]  next_pc,
  output logic [XLEN-1:0]  target_pc,
  output logic             if_flush,
  output logic [CNT_W-1:0] taken_count,
  output logic [CNT_W-1:0] flush_count
);
  localparam int N_EV = 2;

  br_kind_e   kind;
  logic       take_raw;
  logic       take_ok;
  logic [N_EV-1:0]  ev_bump;
  logic [CNT_W-1:0] ev_count [N_EV];

  dec_branch_kind u_kind (
    .sel_eq (sel_eq),
    .sel_ne (sel_ne),
    .kind   (kind)
  );

  dec_branch_cmp #(.XLEN(XLEN)) u_cmp (
    .reg_a (reg_a),
    .reg_b (reg_b),
    .kind  (kind),
    .take  (take_raw)
  );

  dec_branch_target #(.XLEN(XLEN)) u_tgt (
    .seq_pc     (seq_pc),
    .offset_ext (offset_ext),
    .target_pc  (target_pc)
  );

  // A decision only counts when the operands are valid and reset is released.
  assign take_ok  = take_raw & opnd_ready & ~rst;
  assign redirect = take_ok;
  assign if_flush = take_ok;
  assign next_pc  = take_ok ? target_pc : seq_pc;

  // Event 0: taken branch, event 1: flush cycle
  assign ev_bump[0] = take_ok;
  assign ev_bump[1] = if_flush;

  for (genvar g = 0; g < N_EV; g++) begin : g_ev
    dec_branch_evcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .bump  (ev_bump[g]),
      .count (ev_count[g])
    );
  end

  assign taken_count = ev_count[0];
  assign flush_count = ev_count[1];
endmodule

// File: rtl/dec_branch_unit_chk.sv
module dec_branch_unit_chk #(
  parameter int XLEN  = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  seq_pc,
  input logic             sel_eq,
  input logic             sel_ne,
  input logic             opnd_ready,
  input logic             redirect,
  input logic [XLEN-1:0]  next_pc,
  input logic [XLEN-1:0]  target_pc,
  input logic             if_flush,
  input logic [CNT_W-1:0] taken_count,
  input logic [CNT_W-1:0] flush_count
);
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |-> (!redirect && !if_flush && next_pc == seq_pc));

  assert_redirect_pick_R5: assert property (@(posedge clk) disable iff (rst)
    (redirect ? (next_pc == target_pc) : (next_pc == seq_pc)));

  assert_flush_matches_R6: assert property (@(posedge clk) disable iff (rst)
    (if_flush == redirect));

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !opnd_ready |-> (!redirect && !if_flush));

  assert_bad_select_R8: assert property (@(posedge clk) disable iff (rst)
    (sel_eq == sel_ne) |-> !redirect);

  assert_taken_step_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (taken_count == CNT_W'($past(taken_count) + CNT_W'($past(redirect)))));

  assert_flush_step_R9: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (flush_count == CNT_W'($past(flush_count) + CNT_W'($past(if_flush)))));
endmodule

bind dec_branch_unit dec_branch_unit_chk #(.XLEN(XLEN), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .seq_pc      (seq_pc),
  .sel_eq      (sel_eq),
  .sel_ne      (sel_ne),
  .opnd_ready  (opnd_ready),
  .redirect    (redirect),
  .next_pc     (next_pc),
  .target_pc   (target_pc),
  .if_flush    (if_flush),
  .taken_count (taken_count),
  .flush_count (flush_count)
);

// File: tb/sim_dec_branch_unit.sv
`timescale 1ns/1ps
module sim_dec_branch_unit;
  localparam int XLEN  = 32;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [XLEN-1:0]  seq_pc = '0, offset_ext = '0, reg_a = '0, reg_b = '0;
  logic             sel_eq = 1'b0, sel_ne = 1'b0, opnd_ready = 1'b1;
  logic             redirect, if_flush;
  logic [XLEN-1:0]  next_pc, target_pc;
  logic [CNT_W-1:0] taken_count, flush_count;

  int compared = 0;
  int mismatched = 0;
  int exp_taken = 0;
  int exp_flush = 0;
  bit pend = 1'b0;

  always #2 clk = ~clk;

  dec_branch_unit #(.XLEN(XLEN), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .seq_pc(seq_pc), .offset_ext(offset_ext),
    .reg_a(reg_a), .reg_b(reg_b), .sel_eq(sel_eq), .sel_ne(sel_ne),
    .opnd_ready(opnd_ready), .redirect(redirect), .next_pc(next_pc),
    .target_pc(target_pc), .if_flush(if_flush),
    .taken_count(taken_count), .flush_count(flush_count)
  );

  task automatic check(string req, string what, longint act, longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One cycle: apply inputs after the edge, compare against the model mid-cycle.
  task automatic step(input bit r, input logic [XLEN-1:0] pc4, input logic [XLEN-1:0] off,
                      input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                      input bit eq, input bit ne, input bit rdy, input string req);
    logic [XLEN-1:0] e_tgt;
    bit e_take;
    @(posedge clk);
    if (rst) begin exp_taken = 0; exp_flush = 0; end
    else if (pend) begin exp_taken++; exp_flush++; end
    #1;
    rst = r; seq_pc = pc4; offset_ext = off; reg_a = a; reg_b = b;
    sel_eq = eq; sel_ne = ne; opnd_ready = rdy;
    #1;
    e_tgt  = pc4 + (off * 4);
    e_take = !r && rdy && ((eq && !ne && a == b) || (ne && !eq && a != b));
    check(req, "target_pc R2", target_pc, e_tgt);
    check(req, "redirect", redirect, e_take);
    check(req, "if_flush R6", if_flush, e_take);
    check(req, "next_pc", next_pc, e_take ? e_tgt : pc4);
    check(req, "taken_count R9", taken_count, exp_taken % (1 << CNT_W));
    check(req, "flush_count R9", flush_count, exp_flush % (1 << CNT_W));
    pend = e_take;
  endtask

  initial begin
    #(4 * 200000);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    // R1: reset, even with a branch that would be taken
    step(1, 32'h100, 32'h4, 32'h5, 32'h5, 1, 0, 1, "R1");
    step(1, 32'h104, 32'h8, 32'h1, 32'h1, 1, 0, 1, "R1");
    step(0, 32'h108, 32'h0, 32'h0, 32'h1, 0, 0, 1, "R1");
    // R3: equal-branch taken and not taken
    step(0, 32'h200, 32'h10, 32'hAA, 32'hAA, 1, 0, 1, "R3");
    step(0, 32'h204, 32'h10, 32'hAA, 32'hAB, 1, 0, 1, "R3");
    // R4: not-equal branch
    step(0, 32'h300, 32'h3, 32'h1, 32'h2, 0, 1, 1, "R4");
    step(0, 32'h304, 32'h3, 32'h7, 32'h7, 0, 1, 1, "R4");
    // R2: backward offset and wraparound
    step(0, 32'h400, 32'hFFFF_FFF0, 32'h9, 32'h9, 1, 0, 1, "R2");
    step(0, 32'h4, 32'hFFFF_FFFE, 32'h9, 32'h9, 1, 0, 1, "R2");
    step(0, 32'hFFFF_FFFC, 32'h0000_7FFF, 32'h0, 32'h1, 0, 1, 1, "R2");
    // R7: stalled branch held, then resolved once
    step(0, 32'h500, 32'h20, 32'h3, 32'h3, 1, 0, 0, "R7");
    step(0, 32'h500, 32'h20, 32'h3, 32'h3, 1, 0, 0, "R7");
    step(0, 32'h500, 32'h20, 32'h3, 32'h3, 1, 0, 1, "R7");
    step(0, 32'h504, 32'h0, 32'h0, 32'h0, 0, 0, 1, "R7");
    // R8: both selects or none
    step(0, 32'h600, 32'h5, 32'h4, 32'h4, 1, 1, 1, "R8");
    step(0, 32'h604, 32'h5, 32'h4, 32'h5, 1, 1, 1, "R8");
    step(0, 32'h608, 32'h5, 32'h4, 32'h4, 0, 0, 1, "R8");
    // R5 / R6 / R9: long mixed run
    for (int i = 0; i < 400; i++) begin
      logic [XLEN-1:0] a = XLEN'(i * 37) & 32'h7;
      logic [XLEN-1:0] b = XLEN'(i * 11) & 32'h7;
      step(0, XLEN'(32'h1000 + 4 * i), XLEN'(i * 977) - 32'd200, a, b,
           (i % 3) != 1, (i % 3) != 0, (i % 5) != 4, "R5");
    end
    // R1: re-reset clears counters
    step(1, 32'h0, 32'h1, 32'h2, 32'h2, 1, 0, 1, "R1");
    step(0, 32'h0, 32'h1, 32'h2, 32'h3, 1, 0, 1, "R1");
    check("R1", "taken_count after reset", taken_count, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule